// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds a small bank of byte-wide configuration registers in two copies. Byte writes from a serial-port front end change only the staging copy. The active copy drives the rest of the chip. Software can change any number of staged bytes. It then writes a 1 to bit 0 of a fixed control address. That bit arms a commit, and the commit moves every staged byte into the active copy on one clock edge. The bit then clears itself.

The front end issues byte requests through one shared address bus, a write strobe with write data, and a read strobe. Reads are combinational. They return the staged value at the address. The update control address reads back its pending bit. Addresses that are not mapped return zero, and writes to them are accepted with no effect. Both copies load the same parameterized defaults on reset.

Top module: `dbuf_regbank`

## Requirements
- R1: While `rst_n` is low, and after it rises, both the staging copy and the active copy hold `RST_VAL`. Byte i occupies bits `[8i+7:8i]`.
- R2: A write to mapped address `BASE_ADDR+i` (i below `NUM_REGS`) changes the value read back at that address on the next clock. `active_o` stays unchanged until a commit.
- R3: A write at address `UPD_ADDR` (0x234) with data bit 0 set arms a commit on the next edge. On the edge after that, every active byte takes its staged value at once.
- R4: Reading `UPD_ADDR` returns 0x01 during the cycle in which a commit is pending. From the cycle after the commit it returns 0x00, so the bit clears itself.
- R5: A write at `UPD_ADDR` with data bit 0 clear arms no commit, and `active_o` keeps its value.
- R6: Any number of writes may occur between two commits. Each address commits the last value written to it.
- R7: A byte write issued in the same cycle as a pending commit is included in that commit. A write one cycle later is not included.
- R8: A write to an unmapped address is accepted and changes neither copy. A read of an unmapped address returns 0x00.
- R9: Only bit 0 of the data written at `UPD_ADDR` has an effect. Bits 7 to 1 of that address always read as 0.
- R10: `rd_data` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | ADDR_W | Byte address shared by reads and writes |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte write data |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | DATA_W | Read data (staged value, pending bit, or zero) |
| active_o | output | NUM_REGS*DATA_W | Active register copy, byte i at bits [8i+7:8i] |

## Verification
The hardest case to reach is the one-cycle window between arming a commit and the commit itself. In that window the pending bit must read 1, the active bytes must not yet have moved, and a byte written in that same cycle must still be included. The bench writes the control address and then, on the very next clock, either reads the control address or writes a data byte. It then checks that a write one cycle later stays staged only.

// File: rtl/dbuf_regbank.sv
module dbuf_regbank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h010,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 10'h234,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL = 64'h8877_6655_4433_2211
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         wr_en,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_REGS*DATA_W-1:0]   active_o
);

  localparam int BANK_W = NUM_REGS * DATA_W;

  logic [BANK_W-1:0]   stage_q, stage_nx, active_q;
  logic [NUM_REGS-1:0] hit;
  logic                upd_pend;
  logic [DATA_W-1:0]   rd_mux;

  wire upd_wr = wr_en && (req_addr == UPD_ADDR);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    assign hit[i] = (req_addr == BASE_ADDR + ADDR_W'(i));
    assign stage_nx[i*DATA_W +: DATA_W] =
      (wr_en && hit[i]) ? wr_data : stage_q[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= RST_VAL;
      active_q <= RST_VAL;
      upd_pend <= 1'b0;
    end else begin
      stage_q  <= stage_nx;
      upd_pend <= upd_wr && wr_data[0];
      if (upd_pend) active_q <= stage_nx;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == UPD_ADDR) rd_mux = DATA_W'(upd_pend);
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) rd_mux = stage_q[i*DATA_W +: DATA_W];
  end

  assign rd_data  = rd_en ? rd_mux : '0;
  assign active_o = active_q;

endmodule

// File: rtl/dbuf_regbank_chk.sv
module dbuf_regbank_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h010,
  parameter logic [ADDR_W-1:0] UPD_ADDR  = 10'h234,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VAL = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       rd_en,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_REGS*DATA_W-1:0] active_o,
  input logic [NUM_REGS*DATA_W-1:0] stage_q,
  input logic                       upd_pend
);

  wire unmapped = (req_addr != UPD_ADDR) &&
                  ((req_addr < BASE_ADDR) ||
                   (req_addr >= BASE_ADDR + ADDR_W'(NUM_REGS)));

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> active_o == RST_VAL);

  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_o) |-> $past(upd_pend));

  assert_commit_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend |=> active_o == stage_q);

  assert_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend |=> !upd_pend);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |-> rd_data == '0);

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

endmodule

bind dbuf_regbank dbuf_regbank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .UPD_ADDR(UPD_ADDR), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .rd_en(rd_en),
  .rd_data(rd_data), .active_o(active_o), .stage_q(stage_q),
  .upd_pend(upd_pend)
);

// File: tb/dbuf_regbank_tb.sv
module dbuf_regbank_tb;

  localparam logic [63:0] DEF = 64'h8877_6655_4433_2211;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  req_addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [63:0] active_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dbuf_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .active_o(active_o)
  );

  // {req, is_write, addr, data-or-expected}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {4'd1, 1'b0, 10'h010, 8'h11},  // R1
    {4'd1, 1'b0, 10'h017, 8'h88},  // R1
    {4'd2, 1'b1, 10'h012, 8'hA5},
    {4'd2, 1'b0, 10'h012, 8'hA5},  // R2
    {4'd6, 1'b1, 10'h012, 8'h3C},
    {4'd6, 1'b1, 10'h015, 8'h0F},
    {4'd6, 1'b0, 10'h012, 8'h3C},  // R6
    {4'd6, 1'b0, 10'h015, 8'h0F},  // R6
    {4'd8, 1'b1, 10'h100, 8'hFF},
    {4'd8, 1'b0, 10'h100, 8'h00},  // R8
    {4'd8, 1'b0, 10'h00F, 8'h00},  // R8
    {4'd8, 1'b0, 10'h018, 8'h00},  // R8
    {4'd4, 1'b0, 10'h234, 8'h00}   // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    wr_en = 1'b1; req_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    rd_en = 1'b1; req_addr = a;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  logic [7:0]  r;
  logic [63:0] exp_act;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 active during reset", active_o, DEF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 active after reset", active_o, DEF);
    chk("R10 idle read", {56'd0, rd_data}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][18]) wr(VEC[v][17:8], VEC[v][7:0]);
      else begin
        rd(VEC[v][17:8], r);
        checks++;
        if (r !== VEC[v][7:0]) begin
          fails++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h",
                   VEC[v][22:19], v, r, VEC[v][7:0]);
        end
      end
    end
    chk("R2 active untouched by staging", active_o, DEF);

    wr(10'h234, 8'hFE);
    @(negedge clk);
    chk("R5 bit0 clear no commit", active_o, DEF);
    rd(10'h234, r);
    chk("R5 no pending", {56'd0, r}, 64'd0);

    wr(10'h234, 8'h01);
    rd(10'h234, r);
    chk("R4 pending reads 1", {56'd0, r}, 64'd1);
    chk("R3 active not yet moved", active_o, DEF);
    @(negedge clk);
    exp_act = DEF;
    exp_act[16 +: 8] = 8'h3C;
    exp_act[40 +: 8] = 8'h0F;
    chk("R3 R6 R8 commit all staged", active_o, exp_act);
    rd(10'h234, r);
    chk("R4 self-cleared", {56'd0, r}, 64'd0);

    wr(10'h234, 8'h01);
    wr(10'h010, 8'h5A);
    wr(10'h011, 8'hC3);
    exp_act[0 +: 8] = 8'h5A;
    chk("R7 same-cycle write committed", active_o, exp_act);
    rd(10'h011, r);
    chk("R7 later write staged only", {56'd0, r}, 64'hC3);

    wr(10'h234, 8'hFF);
    rd(10'h234, r);
    chk("R9 upper bits read 0", {56'd0, r}, 64'd1);
    @(negedge clk);
    exp_act[8 +: 8] = 8'hC3;
    chk("R9 bit0 commits", active_o, exp_act);

    rst_n = 1'b0;
    #1;
    chk("R1 async reset active", active_o, DEF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(10'h012, r);
    chk("R1 staging restored", {56'd0, r}, 64'h33);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule